// File: doc/BRIEF.md
# Alert Class Escalation Sequencer

This block serves one alert class. Every cycle in which any of its alert inputs is high counts as one event. An event adds one to an accumulator, sets sticky cause bits for the alerts involved, and raises the class interrupt. Escalation starts in either of two ways. The first is an event that arrives while the count already stands at or above a programmed threshold. The second is the interrupt staying unacknowledged for a programmed number of cycles.

Escalation then walks through four phases in a fixed order. Each phase has its own length in cycles. Each phase can drive one of the escalation outputs or none; typical uses are a non-maskable interrupt, a lifecycle escalate line and a reset request. After the last phase the class parks in a terminal state, and the last phase's output stays high.

A one-cycle capture strobe marks entry into one selected phase. A small register-style port configures the block and reads back the class state, the count and the causes. The same port accepts a class clear. An auto-lock option stops that clear from working once escalation has begun.

Top module: `esc_class_seq`

## Requirements
- R1: A cycle with any `alert_i` bit high is one event. It adds one to the accumulator, ORs `alert_i` into the sticky cause bits, and sets `irq_o`; all three are visible after that clock edge.
- R2: An event starts escalation (state becomes phase 0 at that edge) when the accumulator before that event is greater than or equal to the threshold. A threshold of 0 means the first event starts escalation.
- R3: With a nonzero deadline D, the state becomes timeout one cycle after `irq_o` rises. Phase 0 starts D cycles after that, unless `irq_o` falls first, in which case the state returns to idle. D = 0 disables this trigger.
- R4: The phases run 0, 1, 2, 3 in order. Each lasts its programmed number of cycles, and a length of 0 counts as 1.
- R5: A phase whose enable is set drives `esc_o[idx]` for exactly its own cycles. At most one `esc_o` bit is high at any time.
- R6: After phase 3 the state is terminal. It stays terminal, with the phase 3 output held high, until a class clear or reset.
- R7: `state_o` and the state register read 0 for idle, 1 for timeout, 2 for terminal, and 4+p for phase p.
- R8: `crashdump_o` is high for exactly the first cycle of the selected phase.
- R9: Writing the cause register clears each cause bit whose write bit is 1. This does not alter the state or `esc_o`.
- R10: A class clear (write 1 in bit 0 of the clear register) returns the state to idle and zeroes the accumulator, so all `esc_o` bits fall.
- R11: With auto-lock set, once escalation starts, class clears are ignored until reset.
- R12: `irq_ack_i` clears `irq_o`. It does not stop an escalation in progress.
- R13: The register map is as follows. 0 is the control word: bit 0 auto-lock, bits 2:1 crash-dump phase, and for phase p a 3-bit field at bit 3+3p holding the output index in its low 2 bits and an enable in its top bit. 1 is the threshold, 2 the deadline, 3 to 6 the phase 0 to 3 lengths, 7 the clear, 8 the causes, 9 the accumulator and 10 the state. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alert_i | input | NUM_ALERTS | Alert event inputs of this class |
| irq_ack_i | input | 1 | Acknowledge of the class interrupt |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| cfg_rdata_o | output | DATA_W | Configuration read data |
| irq_o | output | 1 | Class interrupt |
| esc_o | output | NUM_ESC | Escalation outputs |
| crashdump_o | output | 1 | Capture strobe on selected phase entry |
| state_o | output | 3 | Class state code |

## Verification
A phase counter that is off by one moves every later `esc_o` edge and the capture strobe by a cycle. The bench therefore pins each state and output value to an absolute cycle counted from the triggering event. A wrong state-to-output mapping shows on the very cycle a phase begins, as a wrong or doubled `esc_o` bit. A lock flag that is wrongly cleared, or a cause clear that reaches the sequencer, shows within one cycle as an early return to idle. A timeout counter that is not reset by an acknowledge shows as a phase 0 entry after the deadline has passed with no interrupt pending.

// File: rtl/esc_class_pkg.sv
package esc_class_pkg;
  localparam int NUM_PHASES = 4;
  localparam int ADDR_W     = 4;

  localparam int A_CTRL     = 0;
  localparam int A_THRESH   = 1;
  localparam int A_DEADLINE = 2;
  localparam int A_DUR0     = 3;
  localparam int A_CLEAR    = 7;
  localparam int A_CAUSE    = 8;
  localparam int A_ACCUM    = 9;
  localparam int A_STATE    = 10;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'b000,
    ST_TIMEOUT = 3'b001,
    ST_TERM    = 3'b010,
    ST_PH0     = 3'b100,
    ST_PH1     = 3'b101,
    ST_PH2     = 3'b110,
    ST_PH3     = 3'b111
  } cls_state_e;
endpackage

// File: rtl/esc_class_regs.sv
module esc_class_regs
  import esc_class_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int NUM_ALERTS = 8,
  parameter int ESC_IDX_W  = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cfg_we_i,
  input  logic [ADDR_W-1:0]                    cfg_addr_i,
  input  logic [DATA_W-1:0]                    cfg_wdata_i,
  output logic [DATA_W-1:0]                    cfg_rdata_o,
  input  logic [NUM_ALERTS-1:0]                cause_i,
  input  logic [CNT_W-1:0]                     accum_i,
  input  logic [2:0]                           state_i,
  output logic                                 auto_lock_o,
  output logic [1:0]                           dump_phase_o,
  output logic [NUM_PHASES-1:0]                map_en_o,
  output logic [NUM_PHASES-1:0][ESC_IDX_W-1:0] map_idx_o,
  output logic [CNT_W-1:0]                     thresh_o,
  output logic [CNT_W-1:0]                     deadline_o,
  output logic [NUM_PHASES-1:0][CNT_W-1:0]     dur_o,
  output logic                                 clr_req_o,
  output logic [NUM_ALERTS-1:0]                cause_clr_o
);
  localparam int MAP_W   = ESC_IDX_W + 1;
  localparam int MAP_LSB = 3;

  logic                                 auto_lock_q;
  logic [1:0]                           dump_q;
  logic [NUM_PHASES-1:0]                map_en_q;
  logic [NUM_PHASES-1:0][ESC_IDX_W-1:0] map_idx_q;
  logic [CNT_W-1:0]                     thresh_q, deadline_q;
  logic [NUM_PHASES-1:0][CNT_W-1:0]     dur_q;
  logic [DATA_W-1:0]                    ctrl_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_lock_q <= 1'b0;
      dump_q      <= '0;
      map_en_q    <= '0;
      map_idx_q   <= '0;
      thresh_q    <= '0;
      deadline_q  <= '0;
      dur_q       <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == ADDR_W'(A_CTRL)) begin
        auto_lock_q <= cfg_wdata_i[0];
        dump_q      <= cfg_wdata_i[2:1];
        for (int p = 0; p < NUM_PHASES; p++) begin
          map_idx_q[p] <= cfg_wdata_i[MAP_LSB+p*MAP_W +: ESC_IDX_W];
          map_en_q[p]  <= cfg_wdata_i[MAP_LSB+p*MAP_W+ESC_IDX_W];
        end
      end
      if (cfg_addr_i == ADDR_W'(A_THRESH))   thresh_q   <= cfg_wdata_i[CNT_W-1:0];
      if (cfg_addr_i == ADDR_W'(A_DEADLINE)) deadline_q <= cfg_wdata_i[CNT_W-1:0];
      for (int p = 0; p < NUM_PHASES; p++) begin
        if (cfg_addr_i == ADDR_W'(A_DUR0 + p)) dur_q[p] <= cfg_wdata_i[CNT_W-1:0];
      end
    end
  end

  assign clr_req_o   = cfg_we_i && (cfg_addr_i == ADDR_W'(A_CLEAR)) && cfg_wdata_i[0];
  assign cause_clr_o = (cfg_we_i && (cfg_addr_i == ADDR_W'(A_CAUSE))) ?
                       cfg_wdata_i[NUM_ALERTS-1:0] : '0;

  always_comb begin
    ctrl_rd      = '0;
    ctrl_rd[0]   = auto_lock_q;
    ctrl_rd[2:1] = dump_q;
    for (int p = 0; p < NUM_PHASES; p++) begin
      ctrl_rd[MAP_LSB+p*MAP_W +: ESC_IDX_W]  = map_idx_q[p];
      ctrl_rd[MAP_LSB+p*MAP_W+ESC_IDX_W]     = map_en_q[p];
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      ADDR_W'(A_CTRL):     cfg_rdata_o = ctrl_rd;
      ADDR_W'(A_THRESH):   cfg_rdata_o = DATA_W'(thresh_q);
      ADDR_W'(A_DEADLINE): cfg_rdata_o = DATA_W'(deadline_q);
      ADDR_W'(A_CAUSE):    cfg_rdata_o = DATA_W'(cause_i);
      ADDR_W'(A_ACCUM):    cfg_rdata_o = DATA_W'(accum_i);
      ADDR_W'(A_STATE):    cfg_rdata_o = DATA_W'(state_i);
      default:             cfg_rdata_o = '0;
    endcase
    for (int p = 0; p < NUM_PHASES; p++) begin
      if (cfg_addr_i == ADDR_W'(A_DUR0 + p)) cfg_rdata_o = DATA_W'(dur_q[p]);
    end
  end

  assign auto_lock_o  = auto_lock_q;
  assign dump_phase_o = dump_q;
  assign map_en_o     = map_en_q;
  assign map_idx_o    = map_idx_q;
  assign thresh_o     = thresh_q;
  assign deadline_o   = deadline_q;
  assign dur_o        = dur_q;

  // R9: a cause clear only takes effect through a cause write
  a_r9_cause_clr_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_clr_o) |-> (cfg_we_i && cfg_addr_i == ADDR_W'(A_CAUSE)));
endmodule

// File: rtl/esc_class_accum.sv
module esc_class_accum #(
  parameter int CNT_W      = 16,
  parameter int NUM_ALERTS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ALERTS-1:0] alert_i,
  input  logic                  clr_i,
  input  logic [NUM_ALERTS-1:0] cause_clr_i,
  input  logic                  irq_ack_i,
  output logic                  alert_ev_o,
  output logic [CNT_W-1:0]      accum_o,
  output logic [NUM_ALERTS-1:0] cause_o,
  output logic                  irq_o
);
  logic [CNT_W-1:0]      acc_q;
  logic [NUM_ALERTS-1:0] cause_q;
  logic                  irq_q;

  assign alert_ev_o = |alert_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (clr_i)                          acc_q <= '0;
      else if (alert_ev_o && acc_q != '1) acc_q <= acc_q + CNT_W'(1);  // saturates
      cause_q <= (cause_q & ~cause_clr_i) | alert_i;
      if (alert_ev_o)     irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
    end
  end

  assign accum_o = acc_q;
  assign cause_o = cause_q;
  assign irq_o   = irq_q;

  a_r1_acc_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> accum_o >= $past(accum_o));
  a_r1_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_clr_i == '0) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
  a_r12_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !alert_ev_o) |=> !irq_o);
endmodule

// File: rtl/esc_class_fsm.sv
module esc_class_fsm
  import esc_class_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_ESC   = 4,
  parameter int ESC_IDX_W = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 alert_ev_i,
  input  logic [CNT_W-1:0]                     accum_i,
  input  logic [CNT_W-1:0]                     thresh_i,
  input  logic [CNT_W-1:0]                     deadline_i,
  input  logic                                 irq_i,
  input  logic [NUM_PHASES-1:0][CNT_W-1:0]     dur_i,
  input  logic [NUM_PHASES-1:0]                map_en_i,
  input  logic [NUM_PHASES-1:0][ESC_IDX_W-1:0] map_idx_i,
  input  logic [1:0]                           dump_phase_i,
  input  logic                                 auto_lock_i,
  input  logic                                 clr_req_i,
  output logic [2:0]                           state_o,
  output logic [NUM_ESC-1:0]                   esc_o,
  output logic                                 crashdump_o,
  output logic                                 clr_ok_o
);
  cls_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;
  logic             dump_q;
  logic [1:0]       ph, eff_ph;
  logic             act, acc_trig, ph_last, to_last, starting;

  assign ph       = state_q[1:0];
  assign acc_trig = alert_ev_i && (accum_i >= thresh_i);
  assign ph_last  = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, dur_i[ph]};
  assign to_last  = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, deadline_i};
  assign clr_ok_o = clr_req_i && !lock_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (acc_trig) begin
          state_d = ST_PH0; cnt_d = '0;
        end else if (irq_i && deadline_i != '0) begin
          state_d = ST_TIMEOUT; cnt_d = '0;
        end
      end
      ST_TIMEOUT: begin
        if (acc_trig) begin
          state_d = ST_PH0; cnt_d = '0;
        end else if (!irq_i || deadline_i == '0) begin
          state_d = ST_IDLE; cnt_d = '0;
        end else if (to_last) begin
          state_d = ST_PH0; cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_PH0, ST_PH1, ST_PH2, ST_PH3: begin
        if (ph_last) begin
          state_d = (ph == 2'd3) ? ST_TERM : cls_state_e'({1'b1, ph + 2'd1});
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: ;  // terminal holds
    endcase
    if (clr_ok_o) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end
  end

  assign starting = (state_d == ST_PH0) &&
                    (state_q == ST_IDLE || state_q == ST_TIMEOUT);
  assign lock_d   = lock_q || (starting && auto_lock_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
      dump_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lock_q  <= lock_d;
      dump_q  <= (state_d != state_q) && state_d[2] && (state_d[1:0] == dump_phase_i);
    end
  end

  assign act    = state_q[2] || (state_q == ST_TERM);
  assign eff_ph = (state_q == ST_TERM) ? 2'd3 : ph;

  for (genvar i = 0; i < NUM_ESC; i++) begin : g_esc
    assign esc_o[i] = act && map_en_i[eff_ph] && (map_idx_i[eff_ph] == ESC_IDX_W'(i));
  end

  assign state_o     = state_q;
  assign crashdump_o = dump_q;

  a_r5_single_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(esc_o));
  a_r8_dump_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crashdump_o |=> !crashdump_o);
  a_r6_terminal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TERM && !clr_ok_o) |=> state_q == ST_TERM);
  a_r11_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && act) |=> state_q != ST_IDLE);
  a_r4_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PH1 && !clr_ok_o) |=> (state_q == ST_PH1 || state_q == ST_PH2));
  a_r10_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ok_o |=> (state_q == ST_IDLE && esc_o == '0));
endmodule

// File: rtl/esc_class_seq.sv
module esc_class_seq
  import esc_class_pkg::*;
#(
  parameter int NUM_ALERTS = 8,
  parameter int NUM_ESC    = 4,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ALERTS-1:0] alert_i,
  input  logic                  irq_ack_i,
  input  logic                  cfg_we_i,
  input  logic [3:0]            cfg_addr_i,
  input  logic [DATA_W-1:0]     cfg_wdata_i,
  output logic [DATA_W-1:0]     cfg_rdata_o,
  output logic                  irq_o,
  output logic [NUM_ESC-1:0]    esc_o,
  output logic                  crashdump_o,
  output logic [2:0]            state_o
);
  localparam int ESC_IDX_W = (NUM_ESC > 1) ? $clog2(NUM_ESC) : 1;

  logic                                 auto_lock, clr_req, clr_ok, alert_ev;
  logic [1:0]                           dump_phase;
  logic [NUM_PHASES-1:0]                map_en;
  logic [NUM_PHASES-1:0][ESC_IDX_W-1:0] map_idx;
  logic [CNT_W-1:0]                     thresh, deadline, accum;
  logic [NUM_PHASES-1:0][CNT_W-1:0]     dur;
  logic [NUM_ALERTS-1:0]                cause, cause_clr;
  logic [2:0]                           state;

  esc_class_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_ALERTS(NUM_ALERTS), .ESC_IDX_W(ESC_IDX_W)
  ) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .cause_i(cause), .accum_i(accum), .state_i(state),
    .auto_lock_o(auto_lock), .dump_phase_o(dump_phase), .map_en_o(map_en),
    .map_idx_o(map_idx), .thresh_o(thresh), .deadline_o(deadline), .dur_o(dur),
    .clr_req_o(clr_req), .cause_clr_o(cause_clr)
  );

  esc_class_accum #(.CNT_W(CNT_W), .NUM_ALERTS(NUM_ALERTS)) u_accum (
    .clk_i, .rst_ni, .alert_i, .clr_i(clr_ok), .cause_clr_i(cause_clr), .irq_ack_i,
    .alert_ev_o(alert_ev), .accum_o(accum), .cause_o(cause), .irq_o
  );

  esc_class_fsm #(.CNT_W(CNT_W), .NUM_ESC(NUM_ESC), .ESC_IDX_W(ESC_IDX_W)) u_fsm (
    .clk_i, .rst_ni, .alert_ev_i(alert_ev), .accum_i(accum), .thresh_i(thresh),
    .deadline_i(deadline), .irq_i(irq_o), .dur_i(dur), .map_en_i(map_en),
    .map_idx_i(map_idx), .dump_phase_i(dump_phase), .auto_lock_i(auto_lock),
    .clr_req_i(clr_req), .state_o(state), .esc_o, .crashdump_o, .clr_ok_o(clr_ok)
  );

  assign state_o = state;
endmodule

// File: tb/esc_class_seq_bench.sv
module esc_class_seq_bench;
  localparam int NA = 8, NE = 4, DW = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NA-1:0] alert = '0;
  logic          ack = 1'b0, we = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          irq, cd;
  logic [NE-1:0] esc;
  logic [2:0]    st;

  always #4 clk = ~clk;

  esc_class_seq u_esc_class_seq (
    .clk_i(clk), .rst_ni(rst_n), .alert_i(alert), .irq_ack_i(ack), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .irq_o(irq),
    .esc_o(esc), .crashdump_o(cd), .state_o(st)
  );

  typedef struct {
    int         at;
    logic [2:0] st;
    logic [3:0] esc;
    logic       cd;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  int   dur[4] = '{3, 4, 5, 6};
  int   dump_ph = 2;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: compares queued expectations away from both clock edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.at < cyc) check(e.req, 32'd1, 32'd0, "sample missed");
        else check(e.req, {23'd0, st, esc, cd}, {23'd0, e.st, e.esc, e.cd}, "state/esc/dump");
      end
    end
  end

  task automatic push(int at, logic [2:0] s, logic [3:0] e, logic c, string req);
    exp_t x;
    x.at = at; x.st = s; x.esc = e; x.cd = c; x.req = req;
    exp_q.push_back(x);
  endtask

  // R4 R5 R6 R8: expected phase walk from trigger edge e0
  task automatic push_seq(int e0, int n);
    logic [3:0] emap[4];
    emap[0] = 4'b0000; emap[1] = 4'b0001; emap[2] = 4'b0010; emap[3] = 4'b1000;
    for (int k = 0; k < n; k++) begin
      int         base = 0;
      logic [2:0] s = 3'd2;
      logic [3:0] e = 4'b1000;
      logic       c = 1'b0;
      bit         found = 0;
      for (int p = 0; p < 4; p++) begin
        int d = (dur[p] == 0) ? 1 : dur[p];
        if (!found && k < base + d) begin
          found = 1;
          s = 3'(4 + p);
          e = emap[p];
          c = (p == dump_ph) && (k == base);
        end
        base += d;
      end
      push(e0 + k, s, e, c, "R4 R5 R6 R8 phase walk");
    end
  endtask

  function automatic logic [31:0] ctrl_word(bit lock, int dp);
    // p1 -> out0, p2 -> out1, p3 -> out3, p0 none (R13 field layout)
    return 32'(lock) | (32'(dp) << 1) | (32'd1 << 8) | (32'd1 << 9) | (32'd1 << 11)
           | (32'd3 << 12) | (32'd1 << 14);
  endfunction

  task automatic cfg_write(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cfg_read(int a, output logic [31:0] d);
    addr = 4'(a);
    #1;
    d = rdata;
  endtask

  task automatic fire(logic [NA-1:0] m);
    @(negedge clk);
    alert = m;
    @(negedge clk);
    alert = '0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7", {28'd0, st, irq}, 32'd0, "reset state/irq");
    check("R5", 32'(esc), 32'd0, "reset esc");
    cfg_read(9, v); check("R1", v, 32'd0, "reset accum");

    // scenario: threshold 0, phase walk, cause clear mid-run (R2 R9)
    cfg_write(0, ctrl_word(0, 2));
    for (int p = 0; p < 4; p++) cfg_write(3 + p, 32'(dur[p]));
    cfg_read(0, v); check("R13", v, ctrl_word(0, 2), "ctrl readback");
    @(negedge clk);
    e0 = cyc + 1;
    push_seq(e0, 22);
    alert = 8'h05;
    @(negedge clk);
    alert = '0;
    check("R2", 32'(st), 32'd4, "threshold 0 first alert");
    check("R1", 32'(irq), 32'd1, "irq raised");
    cfg_read(8, v); check("R1", v, 32'h05, "cause bits");
    cfg_read(9, v); check("R1", v, 32'd1, "accum one");
    cfg_write(8, 32'hFF);  // R9 clear causes during escalation
    cfg_read(8, v); check("R9", v, 32'h0, "cause cleared");
    drain();
    check("R6", {28'd0, st, 1'b0}, {28'd0, 3'd2, 1'b0}, "terminal");
    cfg_write(7, 32'd1);
    check("R10", 32'(st), 32'd0, "clear to idle");
    check("R10", 32'(esc), 32'd0, "clear drops esc");
    cfg_read(9, v); check("R10", v, 32'd0, "clear zeroes accum");
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R12", 32'(irq), 32'd0, "ack clears irq");

    // scenario: threshold 2 (R2)
    cfg_write(1, 32'd2);
    fire(8'h01);
    cfg_read(9, v); check("R1", v, 32'd1, "accum after 1");
    check("R2", 32'(st), 32'd0, "below threshold idle 1");
    fire(8'h02);
    cfg_read(9, v); check("R1", v, 32'd2, "accum after 2");
    check("R2", 32'(st), 32'd0, "below threshold idle 2");
    fire(8'h04);
    check("R2", 32'(st), 32'd4, "third alert escalates");
    cfg_read(8, v); check("R1", v, 32'h07, "sticky causes");
    cfg_write(7, 32'd1);
    check("R10", 32'(st), 32'd0, "clear from phase 0");
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;

    // scenario: deadline 5 (R3), ack during escalation (R12)
    cfg_write(1, 32'd100);
    cfg_write(2, 32'd5);
    @(negedge clk);
    e0 = cyc + 1;
    push(e0,     3'd0, 4'd0, 1'b0, "R3 idle at event");
    push(e0 + 1, 3'd1, 4'd0, 1'b0, "R3 timeout entry");
    push(e0 + 5, 3'd1, 4'd0, 1'b0, "R3 still timeout");
    push(e0 + 6, 3'd4, 4'd0, 1'b0, "R3 deadline phase 0");
    alert = 8'h10;
    @(negedge clk);
    alert = '0;
    drain();
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R12", 32'(irq), 32'd0, "ack during escalation");
    check("R12", 32'(st[2]), 32'd1, "escalation continues after ack");
    cfg_write(7, 32'd1);
    check("R10", 32'(st), 32'd0, "clear after timeout run");

    // scenario: ack before deadline returns to idle (R3)
    fire(8'h20);
    @(negedge clk);
    check("R3", 32'(st), 32'd1, "timeout before ack");
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    repeat (2) @(negedge clk);
    check("R3", 32'(st), 32'd0, "ack returns idle");
    repeat (8) @(negedge clk);
    check("R3", 32'(st), 32'd0, "no escalation after ack");

    // scenario: auto-lock, zero-length phase 0, dump on phase 3 (R11 R4 R8)
    cfg_write(2, 32'd0);
    cfg_write(1, 32'd0);
    dur[0] = 0; dump_ph = 3;
    cfg_write(3, 32'd0);
    cfg_write(0, ctrl_word(1, 3));
    @(negedge clk);
    e0 = cyc + 1;
    push_seq(e0, 20);
    alert = 8'h80;
    @(negedge clk);
    alert = '0;
    cfg_write(7, 32'd1);  // must be ignored
    check("R11", 32'(st[2]), 32'd1, "locked clear ignored");
    drain();
    cfg_write(7, 32'd1);
    check("R11", 32'(st), 32'd2, "locked terminal kept");
    check("R6", 32'(esc), 32'h8, "phase 3 output held");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule